// File: doc/BRIEF.md
# Accelerator bus slot mapper

This block sits between a fast CPU clocked by a 17.72 MHz fast clock and a slow host bus whose memory is shared with a video chip. The host bus runs one period per host phase-2 clock cycle. The fast clock is an exact integer multiple of that period. Each period is split in two parts. The video chip owns every fast slot while phase 2 is low. The CPU may use the fast slots that follow the phase-2 rising edge. The video chip can keep driving the bus for a short time after that edge, so the first CPU slot of each window is kept as a guard slot and is never granted.

A bank register inside the block is loaded by the CPU. Its low three bits select one of eight 64 KB images in a 512 KB SRAM. The next three bits select a ROM set, so RAM image and ROM set together give 64 combinations. The seventh bit chooses between full-speed mode and original-speed mode. SRAM traffic always runs at fast-slot rate. I/O register writes and every colour-RAM access are handed to the host bus instead. The CPU is held on a ready line until the host bus has completed one full phase-2 high period for that access.

Top module: `accel_slot_mapper`

## Requirements
- R1: `video_own` is high except during the CPU_SLOTS fast cycles that follow the cycle in which `host_phi2` is first seen high. Before the first such rise after reset, the video side owns every slot.
- R2: In full-speed mode (bank bit 6 = 1), `cpu_slot` is never high in the first CPU-window slot (the guard slot). When no stall is in progress, it is high in each of the other CPU_SLOTS-1 window slots.
- R3: In original-speed mode (bank bit 6 = 0), `cpu_slot` is high in only one cycle per period: the window slot that follows the guard slot.
- R4: After reset the bank register is zero. SRAM image 0 is selected (`sram_addr[18:16]` = 0), ROM set 0 is selected, and `fast_mode` is 0.
- R5: A cycle with `bank_wr` high loads `bank_din` into the bank register, and the new value is visible from the next cycle. `sram_addr` = {bank bits 2:0, `cpu_addr`}, `rom_set` = bank bits 5:3, and `fast_mode` = bank bit 6.
- R6: Addresses 0xD000–0xDFFF are I/O and never assert `sram_sel`, whatever the bank value. Any other address asserts `sram_sel` in a granted cycle with `cpu_req` high.
- R7: `cpu_rdy` goes low in the same cycle as a granted access that is either a write to 0xD000–0xDFFF or a read or write to colour RAM at 0xD800–0xDBFF. It stays low until the cycle after the end of the next complete phase-2 high period. I/O reads outside colour RAM and all SRAM accesses never lower `cpu_rdy`.
- R8: `host_cyc` is high for exactly the phase-2 high period that serves a stalled access. During that period `host_addr` and `host_we` carry the captured address and direction.
- R9: No cycle is granted while a stall is in progress. After the stall is released, the next grant falls in a later CPU window, in the slot after its guard slot.
- R10: The slot position realigns on every phase-2 rising edge. A host period that is shorter or longer than PERIOD still yields a CPU window that starts one cycle after the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (17.72 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| host_phi2 | input | 1 | Host phase-2 clock, synchronous to `clk` |
| bank_wr | input | 1 | Load strobe for the bank register |
| bank_din | input | 7 | New bank register value: image [2:0], ROM set [5:3], fast [6] |
| cpu_req | input | 1 | CPU presents an access this cycle |
| cpu_we | input | 1 | Access is a write |
| cpu_addr | input | 16 | CPU address within the 64 KB image |
| video_own | output | 1 | Current slot belongs to the video chip |
| cpu_slot | output | 1 | Current slot is granted to the CPU |
| cpu_rdy | output | 1 | Low while the CPU must wait |
| sram_sel | output | 1 | Granted access targets the SRAM |
| sram_addr | output | 19 | SRAM address: image bits above the CPU address |
| rom_set | output | 3 | Upper ROM address lines |
| fast_mode | output | 1 | Full-speed mode selected |
| host_cyc | output | 1 | Host-speed access in progress |
| host_we | output | 1 | Direction of the host-speed access |
| host_addr | output | 16 | Address of the host-speed access |

## Verification
A reference model in the bench tracks the phase-2 history, the bank value and the stall state, and it is compared with every output on every cycle. A steady SRAM request stream is run in each mode. In original-speed mode it separates one grant per period from a full window. In full-speed mode it shows the guard slot being skipped. A sweep over all 128 bank values pairs an SRAM address with an I/O address, which tests the image, ROM and mode lines apart from the I/O decode. A rotating mix of SRAM accesses, I/O reads, I/O writes and colour-RAM accesses shows which accesses stall and how long the stall lasts. A final run stretches and shortens the host period to show that the window realigns on each rise.

// File: rtl/accel_slot_mapper.sv
module accel_slot_mapper #(
  parameter int PERIOD    = 16,
  parameter int CPU_SLOTS = 8,
  parameter int GUARD     = 1,
  parameter int ADDR_W    = 16,
  parameter int IMG_BITS  = 3,
  parameter int ROM_BITS  = 3,
  parameter int unsigned IO_LO  = 32'hD000,
  parameter int unsigned IO_HI  = 32'hDFFF,
  parameter int unsigned COL_LO = 32'hD800,
  parameter int unsigned COL_HI = 32'hDBFF,
  localparam int REG_W = IMG_BITS + ROM_BITS + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       host_phi2,
  input  logic                       bank_wr,
  input  logic [REG_W-1:0]           bank_din,
  input  logic                       cpu_req,
  input  logic                       cpu_we,
  input  logic [ADDR_W-1:0]          cpu_addr,
  output logic                       video_own,
  output logic                       cpu_slot,
  output logic                       cpu_rdy,
  output logic                       sram_sel,
  output logic [IMG_BITS+ADDR_W-1:0] sram_addr,
  output logic [ROM_BITS-1:0]        rom_set,
  output logic                       fast_mode,
  output logic                       host_cyc,
  output logic                       host_we,
  output logic [ADDR_W-1:0]          host_addr
);
  localparam int CNT_W    = $clog2(PERIOD);
  localparam int FAST_BIT = IMG_BITS + ROM_BITS;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_BUS} st_t;

  st_t               st_q;
  logic              phi2_q;
  logic [CNT_W-1:0]  slot_q;
  logic [REG_W-1:0]  bank_q;
  logic [ADDR_W-1:0] haddr_q;
  logic              hwe_q;

  wire phi2_rise  = host_phi2 & ~phi2_q;
  wire phi2_fall  = ~host_phi2 & phi2_q;
  wire in_window  = slot_q < CNT_W'(CPU_SLOTS);
  wire past_guard = slot_q >= CNT_W'(GUARD);
  wire mode_ok    = bank_q[FAST_BIT] | (slot_q == CNT_W'(GUARD));
  wire grant      = in_window & past_guard & mode_ok & (st_q == ST_IDLE);
  wire hit_io     = (32'(cpu_addr) >= IO_LO) & (32'(cpu_addr) <= IO_HI);
  wire hit_col    = (32'(cpu_addr) >= COL_LO) & (32'(cpu_addr) <= COL_HI);
  wire slow_hit   = grant & cpu_req & ((hit_io & cpu_we) | hit_col);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phi2_q <= 1'b0;
      slot_q <= LAST;
    end else begin
      phi2_q <= host_phi2;
      if (phi2_rise)
        slot_q <= '0;
      else if (slot_q != LAST)
        slot_q <= slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bank_q <= '0;
    else if (bank_wr)
      bank_q <= bank_din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      haddr_q <= '0;
      hwe_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (slow_hit) begin
          st_q    <= ST_WAIT;
          haddr_q <= cpu_addr;
          hwe_q   <= cpu_we;
        end
        ST_WAIT: if (phi2_rise) st_q <= ST_BUS;
        ST_BUS:  if (phi2_fall) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign video_own = ~in_window;
  assign cpu_slot  = grant;
  assign cpu_rdy   = ~slow_hit & (st_q == ST_IDLE);
  assign sram_sel  = grant & cpu_req & ~hit_io;
  assign sram_addr = {bank_q[IMG_BITS-1:0], cpu_addr};
  assign rom_set   = bank_q[FAST_BIT-1:IMG_BITS];
  assign fast_mode = bank_q[FAST_BIT];
  assign host_cyc  = (st_q == ST_BUS);
  assign host_we   = hwe_q;
  assign host_addr = haddr_q;
endmodule

// File: rtl/accel_slot_mapper_chk.sv
module accel_slot_mapper_chk #(
  parameter int ADDR_W   = 16,
  parameter int IMG_BITS = 3,
  parameter int ROM_BITS = 3,
  parameter int unsigned IO_LO = 32'hD000,
  parameter int unsigned IO_HI = 32'hDFFF,
  localparam int REG_W = IMG_BITS + ROM_BITS + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bank_wr,
  input logic [REG_W-1:0]    bank_din,
  input logic                cpu_req,
  input logic                cpu_we,
  input logic [ADDR_W-1:0]   cpu_addr,
  input logic                video_own,
  input logic                cpu_slot,
  input logic                cpu_rdy,
  input logic                sram_sel,
  input logic [ROM_BITS-1:0] rom_set,
  input logic                fast_mode,
  input logic                host_cyc
);
  wire io_addr = (32'(cpu_addr) >= IO_LO) && (32'(cpu_addr) <= IO_HI);

  p_video_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    video_own |-> !cpu_slot);

  p_guard_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!video_own && $past(video_own)) |-> !cpu_slot);

  p_one_per_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_mode && cpu_slot && !bank_wr) |=> !cpu_slot);

  p_reset_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (rom_set == '0 && !fast_mode));

  p_bank_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |=> (rom_set == $past(bank_din[IMG_BITS+ROM_BITS-1:IMG_BITS])
                 && fast_mode == $past(bank_din[REG_W-1])));

  p_io_not_sram_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sram_sel |-> !io_addr);

  p_io_write_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_slot && cpu_req && cpu_we && io_addr) |-> !cpu_rdy);

  p_host_holds_cpu_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_cyc |-> !cpu_rdy);

  p_no_grant_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rdy && $past(!cpu_rdy)) |-> !cpu_slot);
endmodule

bind accel_slot_mapper accel_slot_mapper_chk #(
  .ADDR_W(ADDR_W), .IMG_BITS(IMG_BITS), .ROM_BITS(ROM_BITS),
  .IO_LO(IO_LO), .IO_HI(IO_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_wr(bank_wr), .bank_din(bank_din),
  .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .video_own(video_own), .cpu_slot(cpu_slot), .cpu_rdy(cpu_rdy),
  .sram_sel(sram_sel), .rom_set(rom_set), .fast_mode(fast_mode),
  .host_cyc(host_cyc)
);

// File: tb/accel_slot_mapper_bench.sv
`timescale 1ns/1ps
module accel_slot_mapper_bench;
  localparam int CPU_SLOTS = 8;
  localparam int GUARD     = 1;

  logic        clk = 1'b0, rst_n = 1'b0, host_phi2 = 1'b0;
  logic        bank_wr = 1'b0, cpu_req = 1'b0, cpu_we = 1'b0;
  logic [6:0]  bank_din = '0;
  logic [15:0] cpu_addr = '0;
  logic        video_own, cpu_slot, cpu_rdy, sram_sel, fast_mode, host_cyc, host_we;
  logic [18:0] sram_addr;
  logic [2:0]  rom_set;
  logic [15:0] host_addr;

  accel_slot_mapper u_accel_slot_mapper (
    .clk(clk), .rst_n(rst_n), .host_phi2(host_phi2), .bank_wr(bank_wr),
    .bank_din(bank_din), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .video_own(video_own), .cpu_slot(cpu_slot), .cpu_rdy(cpu_rdy),
    .sram_sel(sram_sel), .sram_addr(sram_addr), .rom_set(rom_set),
    .fast_mode(fast_mode), .host_cyc(host_cyc), .host_we(host_we),
    .host_addr(host_addr)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  // stimulus for the next cycle
  bit n_req = 0, n_we = 0, n_bwr = 0;
  int n_addr = 0, n_bank = 0;
  // host phase-2 generator
  int ph = CPU_SLOTS, len = 16, next_len = 16;
  // reference model
  int m_since = 1000, m_st = 0, m_bank = 0, m_haddr = 0;
  bit m_prev = 0, m_hwe = 0, bank_written = 0, realign = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step();
    bit win, fast, grant, io, col, slow, rise, fall, phi;
    @(negedge clk);
    phi       = (ph < CPU_SLOTS);
    host_phi2 = phi;
    cpu_req   = n_req;
    cpu_we    = n_we;
    cpu_addr  = 16'(n_addr);
    bank_wr   = n_bwr;
    bank_din  = 7'(n_bank);
    #1;
    win   = (m_since < CPU_SLOTS);
    fast  = ((m_bank >> 6) & 1) != 0;
    grant = win && m_since >= GUARD && (fast || m_since == GUARD) && m_st == 0;
    io    = n_addr >= 'hD000 && n_addr <= 'hDFFF;
    col   = n_addr >= 'hD800 && n_addr <= 'hDBFF;
    slow  = grant && n_req && ((io && n_we) || col);
    chk(realign ? "R10" : "R1", "video_own", int'(video_own), int'(!win));
    chk(m_st != 0 ? "R9" : (fast ? "R2" : "R3"), "cpu_slot", int'(cpu_slot), int'(grant));
    chk("R7", "cpu_rdy", int'(cpu_rdy), int'(!(slow || m_st != 0)));
    chk("R6", "sram_sel", int'(sram_sel), int'(grant && n_req && !io));
    chk(bank_written ? "R5" : "R4", "sram_addr", int'(sram_addr), ((m_bank & 7) << 16) | n_addr);
    chk(bank_written ? "R5" : "R4", "rom_set", int'(rom_set), (m_bank >> 3) & 7);
    chk(bank_written ? "R5" : "R4", "fast_mode", int'(fast_mode), int'(fast));
    chk("R8", "host_cyc", int'(host_cyc), int'(m_st == 2));
    if (m_st == 2) begin
      chk("R8", "host_addr", int'(host_addr), m_haddr);
      chk("R8", "host_we", int'(host_we), int'(m_hwe));
    end
    // advance the model across the coming rising edge
    rise = phi && !m_prev;
    fall = !phi && m_prev;
    case (m_st)
      0: if (slow) begin m_st = 1; m_haddr = n_addr; m_hwe = n_we; end
      1: if (rise) m_st = 2;
      2: if (fall) m_st = 0;
      default: m_st = 0;
    endcase
    if (rise) m_since = 0;
    else if (m_since < 1000) m_since++;
    m_prev = phi;
    if (n_bwr) begin m_bank = n_bank; bank_written = 1; end
    ph++;
    if (ph >= len) begin ph = 0; len = next_len; end
  endtask

  task automatic load_bank(int v);
    n_bwr = 1; n_bank = v; n_req = 0;
    step();
    n_bwr = 0;
  endtask

  task automatic run_pattern(int cycles);
    for (int i = 0; i < cycles; i++) begin
      n_req = 1;
      case (i % 6)
        0: begin n_addr = 'h0800 + i; n_we = (i % 2) != 0; end
        1: begin n_addr = 'hD020; n_we = 1; end
        2: begin n_addr = 'hC000 + i; n_we = 0; end
        3: begin n_addr = 'hD810; n_we = (i % 4) == 3; end
        4: begin n_addr = 'hD000; n_we = 0; end
        default: begin n_addr = 'hDC0D; n_we = 1; end
      endcase
      step();
    end
  endtask

  initial begin
    #250000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R4: reset state seen before any bank load
    n_req = 1; n_we = 0; n_addr = 'h2000;
    for (int i = 0; i < 64; i++) begin n_addr = 'h2000 + i; step(); end   // R3 slow mode
    // R5/R6: sweep every bank value with an SRAM and an I/O address
    for (int v = 0; v < 128; v++) begin
      load_bank(v);
      n_req = 1; n_we = 0; n_addr = 'h1000 + v; step();
      n_addr = 'hD020; step();
      n_addr = 'hDC00 + v; step();
    end
    // R2: full-speed SRAM stream
    load_bank('h40 | 'h0D);
    for (int i = 0; i < 64; i++) begin n_req = 1; n_we = (i % 3) == 0; n_addr = 'h4000 + i; step(); end
    // R7/R8/R9: mixed stream in full speed, then in original speed
    run_pattern(240);
    load_bank('h15);
    run_pattern(160);
    // R10: shortened and stretched host periods
    load_bank('h7F);
    realign = 1;
    next_len = 13;
    run_pattern(80);
    next_len = 21;
    run_pattern(100);
    next_len = 16;
    run_pattern(48);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule